// File: doc/BRIEF.md
# Nested Mask Rank Expander

This block merges two nested bitmasks into a single mask indexed by word position. The primary mask has one bit per upcoming data word, and a set bit means the word passed a first threshold. The secondary mask does not index word positions. Its bit k refers to the k-th set bit of the primary mask, counted in order. It marks which of the words already flagged by the primary mask also pass a second, stricter threshold. The block places each secondary bit on the word position it stands for. The result is a mask, in word order, of the words that pass both thresholds.

Both masks are read with the first element in the most significant bit. Every primary bit gets a rank, which is the number of primary ones ahead of it. The block computes these ranks with segmented prefix counters that run in parallel. Each set primary bit then looks up the secondary bit at its rank. If a secondary bit names a rank that the primary mask never reaches, the block sets a sticky error flag. Only a reset clears it. An output register can be selected by parameter so that the result appears one clock after the masks are presented. Without it, the result is combinational.

Top module: `nmr_expander`

## Requirements
- R1: Element i of `pri_mask` is bit PRI_W-1-i. Element k of `sec_mask` is bit SEC_W-1-k. Element i of `out_mask` is bit PRI_W-1-i. Element 0 is the first in order.
- R2: Output element p is 1 exactly when primary element p is 1 and secondary element r is 1. Here r is the number of primary ones at elements 0..p-1.
- R3: A primary one whose rank r is SEC_W or more never produces an output bit.
- R4: `out_mask` is a subset of `pri_mask`. The number of its ones equals the number of secondary ones at elements below the primary popcount.
- R5: Take a 32-bit primary mask 0x38220812 with an 8-bit secondary mask 0x44. The output is 0x10000800.
- R6: `err_sticky` becomes 1 on the clock edge that samples `in_valid`=1 together with a secondary one at an element index of at least the primary popcount. It does not rise when `in_valid` is 0.
- R7: Once set, `err_sticky` stays at 1 until `rst`. While `rst` is high, `err_sticky`, `out_valid` and, when REG_OUT=1, `out_mask` are 0.
- R8: With REG_OUT=1, `out_valid` and `out_mask` show the inputs sampled at the previous clock edge. With REG_OUT=0 they follow the inputs within the same cycle. `out_mask` is 0 whenever the matching `in_valid` is 0.
- R9: The behaviour holds for the configurations 128/48, 32/8 and 8/8 (primary width / secondary width).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The masks on the inputs are valid this cycle |
| pri_mask | input | PRI_W | Primary mask, first element in MSB |
| sec_mask | input | SEC_W | Secondary mask in rank order, first element in MSB |
| out_valid | output | 1 | `out_mask` is valid |
| out_mask | output | PRI_W | Merged mask by word position, first element in MSB |
| err_sticky | output | 1 | Set by a secondary bit with no matching primary one; cleared by reset |

## Verification
Two functions can act on the same presented pair. The rank expansion can deliver in-range secondary bits to the output in the same cycle that an out-of-range secondary bit raises the error flag. The bench provokes this on purpose with a sparse primary mask and a secondary mask that has ones both below and above the primary popcount. It also reaches the same case through random sparse patterns. A behavioural reference counts ranks and orphans, and on every clock the bench compares both the merged mask and the error flag against it. This shows that an orphan neither suppresses nor corrupts the valid output bits.

// File: rtl/nmr_pkg.sv
`timescale 1ns/1ps
package nmr_pkg;
  // bits needed to hold a count from 0 to n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/nmr_seg_rank.sv
`timescale 1ns/1ps
// Local ranks for one segment: ones ahead of each bit inside the segment.
module nmr_seg_rank #(
  parameter int SEG_W = 16,
  parameter int LW    = 5
) (
  input  logic [SEG_W-1:0]         bits,
  output logic [SEG_W-1:0][LW-1:0] loc_rank,
  output logic [LW-1:0]            seg_total
);
  logic [LW-1:0] run;
  always_comb begin
    run = '0;
    for (int j = 0; j < SEG_W; j++) begin
      loc_rank[j] = run;
      run = run + LW'(bits[j]);
    end
    seg_total = run;
  end
endmodule

// File: rtl/nmr_pick.sv
`timescale 1ns/1ps
// Each set primary element looks up the secondary element at its rank.
module nmr_pick #(
  parameter int PRI_W = 128,
  parameter int SEC_W = 48,
  parameter int RW    = 8
) (
  input  logic [PRI_W-1:0]         pe,
  input  logic [PRI_W-1:0][RW-1:0] rank,
  input  logic [SEC_W-1:0]         se,
  output logic [PRI_W-1:0]         hit
);
  localparam int PADW = 1 << RW;
  logic [PADW-1:0] se_pad;
  assign se_pad = {{(PADW-SEC_W){1'b0}}, se};

  always_comb begin
    for (int i = 0; i < PRI_W; i++)
      hit[i] = pe[i] & se_pad[rank[i]];
  end
endmodule

// File: rtl/nmr_orphan.sv
`timescale 1ns/1ps
// Flags a secondary element whose index reaches past the primary popcount.
module nmr_orphan #(
  parameter int SEC_W = 48,
  parameter int RW    = 8
) (
  input  logic [SEC_W-1:0] se,
  input  logic [RW-1:0]    total,
  output logic             orphan
);
  always_comb begin
    orphan = 1'b0;
    for (int k = 0; k < SEC_W; k++)
      if (se[k] && (k >= int'(total))) orphan = 1'b1;
  end
endmodule

// File: rtl/nmr_expander.sv
`timescale 1ns/1ps
module nmr_expander #(
  parameter int PRI_W   = 128,
  parameter int SEC_W   = 48,
  parameter int SEG_W   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [PRI_W-1:0] pri_mask,
  input  logic [SEC_W-1:0] sec_mask,
  output logic             out_valid,
  output logic [PRI_W-1:0] out_mask,
  output logic             err_sticky
);
  localparam int RW   = nmr_pkg::cnt_w(PRI_W);
  localparam int LW   = nmr_pkg::cnt_w(SEG_W);
  localparam int NSEG = PRI_W / SEG_W;

  initial begin
    if ((PRI_W % SEG_W) != 0 || SEC_W > PRI_W)
      $error("nmr_expander: SEG_W must divide PRI_W and SEC_W must not exceed PRI_W");
  end

  // element-order views: index 0 is the first element (MSB of the port)
  logic [PRI_W-1:0] pe;
  logic [SEC_W-1:0] se;
  always_comb begin
    for (int i = 0; i < PRI_W; i++) pe[i] = pri_mask[PRI_W-1-i];
    for (int k = 0; k < SEC_W; k++) se[k] = sec_mask[SEC_W-1-k];
  end

  // segmented prefix count
  logic [NSEG-1:0][SEG_W-1:0][LW-1:0] loc;
  logic [NSEG-1:0][LW-1:0]            seg_tot;
  logic [NSEG-1:0][RW-1:0]            base;
  logic [RW-1:0]                      total_all;
  logic [PRI_W-1:0][RW-1:0]           rank;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    nmr_seg_rank #(.SEG_W(SEG_W), .LW(LW)) u_seg (
      .bits      (pe[s*SEG_W +: SEG_W]),
      .loc_rank  (loc[s]),
      .seg_total (seg_tot[s])
    );
  end

  always_comb begin
    base[0] = '0;
    for (int s = 1; s < NSEG; s++)
      base[s] = base[s-1] + RW'(seg_tot[s-1]);
    total_all = base[NSEG-1] + RW'(seg_tot[NSEG-1]);
    for (int s = 0; s < NSEG; s++)
      for (int j = 0; j < SEG_W; j++)
        rank[s*SEG_W + j] = base[s] + RW'(loc[s][j]);
  end

  logic [PRI_W-1:0] hit;
  logic             orphan;

  nmr_pick #(.PRI_W(PRI_W), .SEC_W(SEC_W), .RW(RW)) u_pick (
    .pe (pe), .rank (rank), .se (se), .hit (hit)
  );

  nmr_orphan #(.SEC_W(SEC_W), .RW(RW)) u_orph (
    .se (se), .total (total_all), .orphan (orphan)
  );

  logic [PRI_W-1:0] hit_port;
  always_comb begin
    for (int i = 0; i < PRI_W; i++) hit_port[PRI_W-1-i] = hit[i];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        out_mask  <= '0;
      end else begin
        out_valid <= in_valid;
        out_mask  <= in_valid ? hit_port : '0;
      end
    end
  end else begin : g_comb
    always_comb begin
      out_valid = in_valid;
      out_mask  = in_valid ? hit_port : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                      err_sticky <= 1'b0;
    else if (in_valid && orphan)  err_sticky <= 1'b1;
  end

  AST_HIT_SUBSET: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ((hit & ~pe) == '0)); // R4
  AST_HIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(hit) <= $countones(se))); // R2
  AST_FULL_MATCH: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !orphan) |-> ($countones(hit) == $countones(se))); // R4
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_sticky) |-> $past(in_valid && orphan)); // R6
endmodule

// File: tb/sim_nmr_expander.sv
`timescale 1ns/1ps
module sim_nmr_expander;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic         rst, vld;
  logic [127:0] pri;
  logic [47:0]  sec;
  logic         ov0, ov1, ov2, er0, er1, er2;
  logic [127:0] om0;
  logic [31:0]  om1;
  logic [7:0]   om2;

  nmr_expander #(.PRI_W(128), .SEC_W(48), .SEG_W(16), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(vld), .pri_mask(pri), .sec_mask(sec),
    .out_valid(ov0), .out_mask(om0), .err_sticky(er0));
  nmr_expander #(.PRI_W(32), .SEC_W(8), .SEG_W(8), .REG_OUT(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(vld), .pri_mask(pri[31:0]), .sec_mask(sec[7:0]),
    .out_valid(ov1), .out_mask(om1), .err_sticky(er1));
  nmr_expander #(.PRI_W(8), .SEC_W(8), .SEG_W(4), .REG_OUT(1'b0)) u2 (
    .clk(clk), .rst(rst), .in_valid(vld), .pri_mask(pri[7:0]), .sec_mask(sec[7:0]),
    .out_valid(ov2), .out_mask(om2), .err_sticky(er2));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit e0, e1, e2;

  // behavioural reference: walk elements in order, keep a rank counter
  function automatic logic [127:0] ref_mask(logic [127:0] p, logic [47:0] s, int pw, int sw);
    logic [127:0] r = '0;
    int cnt = 0;
    for (int i = 0; i < pw; i++) begin
      if (p[pw-1-i]) begin
        if (cnt < sw && s[sw-1-cnt]) r[pw-1-i] = 1'b1;
        cnt++;
      end
    end
    return r;
  endfunction

  function automatic bit ref_orphan(logic [127:0] p, logic [47:0] s, int pw, int sw);
    int cnt = 0;
    for (int i = 0; i < pw; i++) cnt += int'(p[i]);
    for (int k = cnt; k < sw; k++) if (s[sw-1-k]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; vld = 1'b0; pri = '0; sec = '0;
    repeat (2) @(posedge clk);
    #2;
    chk(ov0 == 1'b0 && om0 == '0, "R7 reset outputs u0", {ov0, om0[126:0]}, '0);
    chk(er0 == 1'b0 && er1 == 1'b0 && er2 == 1'b0, "R7 reset error flags",
        {er0, er1, er2}, '0);
    chk(ov1 == 1'b0 && om1 == '0, "R7 reset outputs u1", {ov1, om1}, '0);
    e0 = 1'b0; e1 = 1'b0; e2 = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one pair; check the combinational instance, then the registered ones
  task automatic apply(logic [127:0] p, logic [47:0] s, bit v, string tag);
    logic [127:0] x0, x1, x2;
    pri = p; sec = s; vld = v;
    x0 = v ? ref_mask(p, s, 128, 48) : '0;
    x1 = v ? ref_mask(p, s, 32, 8)   : '0;
    x2 = v ? ref_mask(p, s, 8, 8)    : '0;
    #2;
    chk(om2 == x2[7:0] && ov2 == v, {tag, " R8 R9 comb 8/8"}, {ov2, om2}, {v, x2[7:0]});
    @(posedge clk);
    #2;
    if (v) begin
      e0 |= ref_orphan(p, s, 128, 48);
      e1 |= ref_orphan(p, s, 32, 8);
      e2 |= ref_orphan(p, s, 8, 8);
    end
    chk(om0 == x0 && ov0 == v, {tag, " R2 R8 128/48"}, om0, x0);
    chk(om1 == x1[31:0] && ov1 == v, {tag, " R2 R9 32/8"}, {ov1, om1}, {v, x1[31:0]});
    chk(er0 == e0 && er1 == e1 && er2 == e2, {tag, " R6 R7 error"},
        {er0, er1, er2}, {e0, e1, e2});
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    do_reset();

    // R6: orphan pattern with in_valid low must not raise the flag
    apply('0, '1, 1'b0, "R6 idle");

    // R5: worked example on the 32/8 instance
    apply({96'h0, 32'h3822_0812}, {40'h0, 8'h44}, 1'b1, "R5 example");
    chk(om1 == 32'h1000_0800, "R5 fixed value", om1, 128'h1000_0800);

    // R1: element order on the 8/8 combinational instance
    apply({120'h0, 8'h80}, {40'h0, 8'h80}, 1'b1, "R1 first elem");
    apply({120'h0, 8'h01}, {40'h0, 8'h80}, 1'b1, "R1 last elem rank0");
    chk(om2 == 8'h01, "R1 fixed value", om2, 128'h01);

    // R3: full primary, full secondary -> only the first 48 elements
    do_reset();
    apply('1, '1, 1'b1, "R3 saturate");
    chk(om0 == {48'hFFFF_FFFF_FFFF, 80'h0}, "R3 fixed value", om0,
        {48'hFFFF_FFFF_FFFF, 80'h0});

    // R4 + R6 together: valid ranks and an orphan in one pair
    apply({8'h90, 112'h0, 8'h21}, {8'h84, 40'h0}, 1'b1, "R4 R6 mixed");
    // R7: clean pairs afterwards leave the flag set
    apply({8'hFF, 120'h0}, {8'hC0, 40'h0}, 1'b1, "R7 sticky");
    apply('0, '0, 1'b0, "R7 sticky idle");
    do_reset();

    // random patterns of varying density, periodic resets
    for (int n = 0; n < 400; n++) begin
      logic [127:0] p;
      logic [47:0]  s;
      p = {$urandom, $urandom, $urandom, $urandom};
      if (n % 3 == 1) p &= {$urandom, $urandom, $urandom, $urandom};
      if (n % 3 == 2) p |= {$urandom, $urandom, $urandom, $urandom};
      s = {$urandom, $urandom};
      if (n % 4 == 0) s &= {$urandom, $urandom};
      apply(p, s, ($urandom % 8) != 0, "R2 R4 random");
      if (n % 25 == 24) do_reset();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule